// File: doc/BRIEF.md
# Serial-Bus Potentiometer Command Slave

This block is the serial front end of a single-channel digital potentiometer. It sits on a two-wire bus as a target device and runs on the system clock. It samples the bus clock and data lines through a synchronizer and a glitch filter, then detects start and stop conditions.

It answers to one 7-bit address. The upper six bits of that address are a parameter, and the lowest bit follows a strap input. A write frame carries an instruction byte and then a wiper byte. When the frame completes, the block issues a one-cycle strobe that carries the midscale-reset flag, the shutdown flag and the wiper byte. A read frame returns the wiper register value supplied by the register block. The block keeps sending that value for as long as the master acknowledges each byte.

The data line is driven open-drain: when `sda_oe` is high, the line is pulled low. Otherwise the line is released.

Top module: `i2c_pot_slave`

## Requirements
- R1: A falling data line while the bus clock is high is a start, and a rising data line while the clock is high is a stop. Data bits are sampled only on rising clock edges, so a start and stop with no bits in between changes nothing.
- R2: After a start, the block acknowledges by holding `sda_oe` high through the ninth clock pulse when all of these hold:
  - the first received byte has bits 7..2 equal to `DEV_ID` (default 010110);
  - bit 1 of that byte equals `strap_a0`.
  Bit 0 of the byte selects the direction: 0 is write, 1 is read.
- R3: On an address mismatch, `sda_oe` stays low for the rest of the frame and no strobe is issued until the next start.
- R4: In a write frame, the block acknowledges both the instruction byte and the data byte.
- R5: In the instruction byte, bit 6 sets `instr_rs` and bit 5 sets `instr_sd`. All other instruction bits are ignored.
- R6: `wr_valid` is high for exactly one clock per completed write frame. It rises after the clock falling edge that ends the eighth data bit and before the acknowledge pulse. At that point `wr_data` holds the data byte.
- R7: In a read frame, `rd_data` is shifted out MSB first. Each bit is placed on the line while the bus clock is low.
- R8: After each read byte, the block releases the line and samples the master's acknowledge bit:
  - on acknowledge, it reloads `rd_data` and sends it again;
  - on no-acknowledge, it keeps the line released until the next start or stop.
- R9: A repeated start in the middle of a frame restarts address reception. A stop before the data byte completes discards the partial write.
- R10: A bus-clock pulse shorter than `FILT_LEN` system clocks is ignored.
- R11: After reset, `sda_oe` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| strap_a0 | input | 1 | Address bit 1 strap level |
| rd_data | input | 8 | Current wiper register value |
| wr_valid | output | 1 | One-cycle write strobe |
| instr_rs | output | 1 | Midscale-reset flag of the last write |
| instr_sd | output | 1 | Shutdown flag of the last write |
| wr_data | output | 8 | Wiper byte of the last write |

## Verification
The bench builds the block with its default parameters: `DEV_ID` of 010110 and a four-sample filter. The master model injects two-cycle spikes on the bus clock while the clock is low, which is inside the range the filter must reject. The strap is switched between both levels, so that matching and non-matching addresses occur for each strap value. Read frames of one to three bytes exercise reload on acknowledge, release on no-acknowledge, and a change of `rd_data` between bytes.

// File: rtl/i2c_pot_slave.sv
`timescale 1ns/1ps
module i2c_pot_slave #(
  parameter logic [5:0] DEV_ID   = 6'b010110,
  parameter int         FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a0,
  input  logic [7:0] rd_data,
  output logic       wr_valid,
  output logic       instr_rs,
  output logic       instr_sd,
  output logic [7:0] wr_data
);
  localparam int FW = $clog2(FILT_LEN + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_READ, ST_WAIT} state_t;

  logic [1:0]    s1, s2, flt, flt_p;
  logic [FW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; flt_p <= 2'b11;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      s1 <= {sda_i, scl_i};
      s2 <= s1;
      flt_p <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FW'(FILT_LEN - 1)) begin
          flt[i]  <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  logic scl_q, sda_q, scl_rise, scl_fall, start, stop;
  assign scl_q    = flt[0];
  assign sda_q    = flt[1];
  assign scl_rise = scl_q & ~flt_p[0];
  assign scl_fall = ~scl_q & flt_p[0];
  assign start    = scl_q & flt_p[0] & flt_p[1] & ~sda_q;
  assign stop     = scl_q & flt_p[0] & ~flt_p[1] & sda_q;

  state_t     state;
  logic [3:0] cnt;
  logic [7:0] sreg, txreg;
  logic       rw, rs_hold, sd_hold, active;

  assign active = (state == ST_ADDR) || (state == ST_INSTR) ||
                  (state == ST_DATA) || (state == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sreg <= '0; txreg <= '0;
      rw <= 1'b0; rs_hold <= 1'b0; sd_hold <= 1'b0; sda_oe <= 1'b0;
      wr_valid <= 1'b0; instr_rs <= 1'b0; instr_sd <= 1'b0; wr_data <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start) begin
        state <= ST_ADDR; cnt <= 4'd15; sda_oe <= 1'b0;
      end else if (stop) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        if (scl_rise) sreg <= {sreg[6:0], sda_q};
        if (scl_fall && active) begin
          if (cnt == 4'd15) cnt <= '0;
          else if (cnt == 4'd7) begin
            cnt <= 4'd8;
            case (state)
              ST_ADDR:
                if (sreg[7:1] == {DEV_ID, strap_a0}) begin
                  sda_oe <= 1'b1; rw <= sreg[0];
                end else begin
                  state <= ST_WAIT; sda_oe <= 1'b0;
                end
              ST_INSTR: begin sda_oe <= 1'b1; rs_hold <= sreg[6]; sd_hold <= sreg[5]; end
              ST_DATA: begin
                sda_oe <= 1'b1; wr_valid <= 1'b1;
                instr_rs <= rs_hold; instr_sd <= sd_hold; wr_data <= sreg;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd8) begin
            cnt <= '0;
            case (state)
              ST_ADDR:
                if (rw) begin
                  state <= ST_READ; txreg <= rd_data; sda_oe <= ~rd_data[7];
                end else begin
                  state <= ST_INSTR; sda_oe <= 1'b0;
                end
              ST_INSTR: begin state <= ST_DATA; sda_oe <= 1'b0; end
              ST_DATA:  begin state <= ST_WAIT; sda_oe <= 1'b0; end
              default:
                if (!sreg[0]) begin
                  txreg <= rd_data; sda_oe <= ~rd_data[7];
                end else begin
                  state <= ST_WAIT; sda_oe <= 1'b0;
                end
            endcase
          end else begin
            cnt <= cnt + 1'b1;
            if (state == ST_READ) begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
        end
      end
    end
  end

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_strobe_clock_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !scl_q);
  assert_line_steady_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && flt_p[0] && !start && !stop) |=> $stable(sda_oe));
  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);
  assert_silent_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe);
endmodule

// File: tb/i2c_pot_slave_tb.sv
`timescale 1ns/1ps
module i2c_pot_slave_tb;
  localparam int HP = 20;
  localparam int Q  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0, strap = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, wr_valid, instr_rs, instr_sd;
  logic [7:0] wr_data;
  logic sda_line, scl_line;

  assign sda_line = m_sda & ~sda_oe;
  assign scl_line = m_scl | glitch;

  always #4 clk = ~clk;

  i2c_pot_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a0(strap), .rd_data(rd_data), .wr_valid(wr_valid), .instr_rs(instr_rs),
    .instr_sd(instr_sd), .wr_data(wr_data));

  int nchk = 0, nfail = 0, pulses = 0, long_pulses = 0, snap = 0;
  logic last_rs, last_sd, prev_wv = 1'b0;
  logic [7:0] last_data;
  bit done = 0;

  always @(posedge clk) begin
    if (wr_valid) begin
      pulses++;
      last_rs = instr_rs; last_sd = instr_sd; last_data = wr_data;
      if (prev_wv) long_pulses++;
    end
    prev_wv = wr_valid;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit addr_hit(logic [7:0] a, logic s);
    return (a[7:2] == 6'b010110) && (a[1] == s);
  endfunction

  task automatic bus_start;
    m_sda = 1; tick(HP); m_scl = 1; tick(HP); m_sda = 0; tick(HP); m_scl = 0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; tick(HP); m_scl = 1; tick(HP); m_sda = 1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(HP);
      if (gl) begin glitch = 1; tick(2); glitch = 0; tick(2); end
      m_scl = 1; tick(HP); m_scl = 0; tick(Q);
    end
    m_sda = 1; tick(HP); snap = pulses;
    m_scl = 1; tick(HP/2); acked = !sda_line; tick(HP/2); m_scl = 0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(HP); m_scl = 1; tick(HP/2); b[i] = sda_line; tick(HP/2); m_scl = 0; tick(Q);
    end
    m_sda = !mack; tick(HP); m_scl = 1; tick(HP); m_scl = 0; tick(Q); m_sda = 1;
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] ins, logic [7:0] d, bit gl, output logic [2:0] acks);
    bit k;
    bus_start;
    send_byte(a, gl, k);   acks[2] = k;
    send_byte(ins, gl, k); acks[1] = k;
    send_byte(d, gl, k);   acks[0] = k;
    bus_stop;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] b;
    bit k;
    int p0;
    tick(10);
    check("R11 sda_oe reset", sda_oe, 0);
    check("R11 wr_valid reset", wr_valid, 0);
    rst_n = 1; tick(10);

    p0 = pulses;
    bus_start;
    send_byte(8'h58, 0, k); check("R2 address ack", k, 1);
    send_byte(8'h40, 0, k); check("R4 instr ack", k, 1);
    send_byte(8'h3C, 0, k); check("R4 data ack", k, 1);
    check("R6 strobe before ack pulse", snap, p0 + 1);
    bus_stop;
    check("R6 one strobe", pulses, p0 + 1);
    check("R5 rs flag", last_rs, 1);
    check("R5 sd flag", last_sd, 0);
    check("R6 data byte", last_data, 8'h3C);

    for (int it = 0; it < 24; it++) begin
      logic [7:0] a, ins, d;
      bit hit, gl;
      strap = $urandom() & 1;
      a = ($urandom() % 4 != 0) ? {6'b010110, strap, 1'b0} : 8'($urandom()) & 8'hFE;
      ins = 8'($urandom()); d = 8'($urandom()); gl = $urandom() & 1;
      hit = addr_hit(a, strap);
      p0 = pulses;
      do_write(a, ins, d, gl, acks);
      check(gl ? "R10 filtered write acks" : "R2 R3 write acks", acks, hit ? 3'b111 : 3'b000);
      check("R6 R3 strobe count", pulses, p0 + (hit ? 1 : 0));
      if (hit) begin
        check("R5 rs random", last_rs, ins[6]);
        check("R5 sd random", last_sd, ins[5]);
        check(gl ? "R10 data under glitch" : "R6 data random", last_data, d);
      end
    end
    check("R6 strobe width", long_pulses, 0);

    strap = 1; p0 = pulses;
    do_write(8'h58, 8'h60, 8'h11, 0, acks);
    check("R3 strap mismatch silent", acks, 0);
    check("R3 no strobe", pulses, p0);
    check("R3 line released", sda_oe, 0);

    strap = 0; rd_data = 8'hA7;
    bus_start;
    send_byte(8'h59, 0, k); check("R2 read address ack", k, 1);
    rd_data = 8'h3E;
    recv_byte(1, b); check("R7 first read byte", b, 8'hA7);
    recv_byte(0, b); check("R8 reload after ack", b, 8'h3E);
    recv_byte(0, b); check("R8 released after nack", b, 8'hFF);
    bus_stop;

    for (int it = 0; it < 8; it++) begin
      logic [7:0] v;
      int n;
      strap = $urandom() & 1; v = 8'($urandom()); rd_data = v; n = 1 + $urandom() % 3;
      bus_start;
      send_byte({6'b010110, strap, 1'b1}, 0, k); check("R2 random read ack", k, 1);
      for (int j = 0; j < n; j++) begin
        recv_byte(j != n - 1, b); check("R7 R8 random read", b, v);
      end
      bus_stop;
    end

    strap = 0; p0 = pulses;
    bus_start; send_byte(8'h58, 0, k); send_byte(8'h20, 0, k); bus_stop;
    check("R9 stop before data discards", pulses, p0);

    p0 = pulses;
    bus_start; send_byte(8'h58, 0, k); send_byte(8'h40, 0, k);
    bus_start;
    send_byte(8'h58, 0, k); check("R9 R1 repeated start address", k, 1);
    send_byte(8'h20, 0, k); send_byte(8'hA5, 0, k);
    bus_stop;
    check("R9 one strobe after restart", pulses, p0 + 1);
    check("R9 sd after restart", last_sd, 1);
    check("R9 rs after restart", last_rs, 0);
    check("R9 data after restart", last_data, 8'hA5);

    p0 = pulses;
    bus_start; bus_stop;
    check("R1 empty frame no strobe", pulses, p0);
    check("R1 empty frame line released", sda_oe, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule